// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After power-up, and again whenever it is told to, this sequencer walks a serial EEPROM image one byte at a time. It fetches each byte through a request/response pair that stands in for the two-wire bus controller. The image has three sections, and each one is guarded by its own A5h signature byte. The first section is a 48-bit station (MAC) address. The second is nine bytes of strap configuration. The third is a list of register-write bursts, which the loader replays onto a plain register write port. While it works, the loader raises `busy` and drops `dev_ready`. When it finishes, it swaps the two.

The read request and the register write are valid/ready channels. A request or a write is offered with `*_valid` and is held, with its address and data unchanged, until the cycle in which `*_ready` is high. That cycle is the transfer. Back-pressure on either channel only stretches the load. The response channel has no ready signal: the loader accepts a byte in any cycle that `rd_rsp_valid` is high. Only one read is outstanding at a time.

The loader is started in four ways: release of `rst_n`, a pin-reset pulse, a soft-reset pulse, or a reload pulse. The two reset pulses always restart the load from address 0. A reload pulse is acted on only while the loader is idle.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: `busy` is 1 and `dev_ready` is 0 while `rst_n` is low, and from the first clock edge that samples a start until the load ends. After the load ends, `busy` is 0 and `dev_ready` is 1.
- R2: If the byte at address 0 is not A5h, exactly one read is made, and `mac_addr` and `strap_cfg` keep their previous values. After `rst_n`, those values are the parameter defaults.
- R3: The bytes at addresses 1 to 6 form `mac_addr`. The byte at address 1 goes to bits [7:0], and the byte at address 6 goes to bits [47:40]. The new value is committed only after all six bytes have arrived.
- R4: If address 7 holds A5h, addresses 8 to 16 form `strap_cfg`, with the byte at address 8+k going to bits [8k+7:8k]. Otherwise addresses 8 to 16 are not read, the next read is address 17, and `strap_cfg` is unchanged.
- R5: If address 17 holds A5h, address 18 gives the burst count. Bursts follow from address 19. Each burst is: register address low byte, register address high byte, word count N, then N 32-bit words sent least significant byte first. The words are written to the register address, then that address plus 4, and so on.
- R6: A burst with N = 0 produces no write and is followed directly by the next burst. A burst count of 0 ends the load after the read of address 18.
- R7: `wr_valid`, `wr_addr` and `wr_data` are held stable until `wr_ready` is high. No further read request is made until the write has been accepted.
- R8: `rd_req_valid` and `rd_req_addr` are held until `rd_req_ready` is high. At most one read is outstanding. Read addresses rise by one, except for the jump from 7 to 17 and a restart at 0.
- R9: A reload pulse while `busy` is 1 is ignored: the load carries on with no restart. A reload pulse while idle starts a load.
- R10: A pin-reset or soft-reset pulse while busy abandons the load. Any pending request or write is withdrawn, and a late response to an abandoned read is discarded. The load restarts at address 0.
- R11: A response with `rd_rsp_err` high ends the load. Sections already committed are kept. `load_err` becomes 1 and stays 1 until `rst_n` is asserted.
- R12: If address 17 does not hold A5h, the load ends after that read with no register write. The MAC address and straps loaded in the same pass are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; a load starts on its release |
| pin_rst_trig | input | 1 | Pin-reset pulse, restarts the load |
| soft_rst_trig | input | 1 | Soft-reset pulse, restarts the load |
| reload_cmd | input | 1 | Reload pulse, acted on only while idle |
| rd_req_valid | output | 1 | EEPROM byte read request |
| rd_req_ready | input | 1 | Request accepted |
| rd_req_addr | output | ADDR_W (11) | EEPROM byte address |
| rd_rsp_valid | input | 1 | Read byte returned |
| rd_rsp_data | input | 8 | Returned byte |
| rd_rsp_err | input | 1 | Read failed |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | REG_AW (16) | Register address |
| wr_data | output | REG_DW (32) | Register data |
| busy | output | 1 | Load in progress |
| dev_ready | output | 1 | Device usable (no load running) |
| load_err | output | 1 | Sticky read-error flag |
| mac_addr | output | 48 | Station address |
| strap_cfg | output | 72 | Strap configuration bytes |

## Verification
A start pulse is sampled on one clock edge, and `busy` is already high by the following falling edge. The bench therefore checks `busy` and `dev_ready` one cycle after it releases a pulse. `mac_addr` and `strap_cfg` change at the same edge that accepts the last byte of their section. `busy` falls at the edge that takes the last read or write, so every end-state value is sampled on the first falling edge at which `busy` is low. Register writes are compared one by one against a queue at the falling edge before the accepting clock edge, when `wr_valid` and `wr_ready` are both settled. The number of read transfers is counted the same way and compared with the count the image layout implies. For the abort test, that count is taken at the moment the reset pulse is driven.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam logic [7:0] SIG_OK = 8'hA5;
  localparam int MAC_BYTES   = 6;
  localparam int STRAP_BYTES = 9;
  localparam int A_SIG   = 0;
  localparam int A_MAC   = 1;
  localparam int A_SSIG  = A_MAC + MAC_BYTES;
  localparam int A_STRAP = A_SSIG + 1;
  localparam int A_BSIG  = A_STRAP + STRAP_BYTES;
  localparam int A_NB    = A_BSIG + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SIG, ST_MAC, ST_SSIG, ST_STRAP, ST_BSIG,
    ST_NBURST, ST_BADDR, ST_BCNT, ST_WORD, ST_WRITE
  } ld_state_e;
endpackage

// File: rtl/ldr_trigger.sv
module ldr_trigger (
  input  logic pin_rst,
  input  logic soft_rst,
  input  logic reload,
  input  logic busy,
  output logic restart,
  output logic start
);
  assign restart = pin_rst | soft_rst;
  assign start   = restart | (reload & ~busy);
endmodule

// File: rtl/ldr_shift.sv
module ldr_shift #(
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [7:0]      din,
  output logic [8*NB-1:0] nxt
);
  localparam int W = 8 * NB;
  logic [W-1:0] q;

  generate
    if (NB == 1) begin : g_single
      assign nxt = din;
    end else begin : g_multi
      assign nxt = {din, q[W-1:8]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/ldr_byte_reader.sv
module ldr_byte_reader #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          idle,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_err,
  output logic          byte_vld,
  output logic [7:0]    byte_dat,
  output logic          byte_err
);
  logic pend, drop;

  assign idle = ~req_valid & ~pend & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      pend      <= 1'b0;
      drop      <= 1'b0;
      byte_vld  <= 1'b0;
      byte_dat  <= '0;
      byte_err  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (abort) begin
        req_valid <= 1'b0;
        pend      <= 1'b0;
        drop      <= (pend & ~rsp_valid) | (req_valid & req_ready) | (drop & ~rsp_valid);
      end else begin
        if (go && idle) begin
          req_valid <= 1'b1;
          req_addr  <= go_addr;
        end
        if (req_valid && req_ready) begin
          req_valid <= 1'b0;
          pend      <= 1'b1;
        end
        if (rsp_valid) begin
          if (drop) begin
            drop <= 1'b0;
          end else if (pend) begin
            pend     <= 1'b0;
            byte_vld <= 1'b1;
            byte_dat <= rsp_data;
            byte_err <= rsp_err;
          end
        end
      end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort |=> req_valid && $stable(req_addr));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_valid);
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int REG_AW = 16,
  parameter int REG_DW = 32,
  parameter logic [8*MAC_BYTES-1:0]   MAC_DEFAULT   = 48'h02_00_5E_10_20_30,
  parameter logic [8*STRAP_BYTES-1:0] STRAP_DEFAULT = 72'h00_11_22_33_44_55_66_77_88
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pin_rst_trig,
  input  logic                       soft_rst_trig,
  input  logic                       reload_cmd,
  output logic                       rd_req_valid,
  input  logic                       rd_req_ready,
  output logic [ADDR_W-1:0]          rd_req_addr,
  input  logic                       rd_rsp_valid,
  input  logic [7:0]                 rd_rsp_data,
  input  logic                       rd_rsp_err,
  output logic                       wr_valid,
  input  logic                       wr_ready,
  output logic [REG_AW-1:0]          wr_addr,
  output logic [REG_DW-1:0]          wr_data,
  output logic                       busy,
  output logic                       dev_ready,
  output logic                       load_err,
  output logic [8*MAC_BYTES-1:0]     mac_addr,
  output logic [8*STRAP_BYTES-1:0]   strap_cfg
);
  localparam int MAC_W      = 8 * MAC_BYTES;
  localparam int STRAP_W    = 8 * STRAP_BYTES;
  localparam int ADR_BYTES  = REG_AW / 8;
  localparam int WORD_BYTES = REG_DW / 8;
  localparam int IDX_W      = $clog2(STRAP_BYTES + 1);

  ld_state_e         state;
  logic [ADDR_W-1:0] ptr;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        bursts_left, words_left;
  logic              fetching;
  logic              restart, start, go, is_rd;
  logic              rdr_idle, byte_vld, byte_err;
  logic [7:0]        byte_dat;
  logic              take;
  logic [MAC_W-1:0]   mac_nxt;
  logic [STRAP_W-1:0] strap_nxt;
  logic [REG_AW-1:0]  badr_nxt;
  logic [REG_DW-1:0]  word_nxt;

  ldr_trigger u_trig (
    .pin_rst(pin_rst_trig), .soft_rst(soft_rst_trig), .reload(reload_cmd),
    .busy(busy), .restart(restart), .start(start)
  );

  assign is_rd = state inside {ST_SIG, ST_MAC, ST_SSIG, ST_STRAP, ST_BSIG,
                               ST_NBURST, ST_BADDR, ST_BCNT, ST_WORD};
  assign go    = is_rd & ~fetching & rdr_idle & ~start;
  assign take  = byte_vld & ~start;

  ldr_byte_reader #(.AW(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .abort(restart), .go(go), .go_addr(ptr),
    .idle(rdr_idle), .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .req_addr(rd_req_addr), .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .rsp_err(rd_rsp_err), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_err(byte_err)
  );

  ldr_shift #(.NB(MAC_BYTES)) u_mac_sh (
    .clk(clk), .rst_n(rst_n), .en(take && state == ST_MAC), .din(byte_dat), .nxt(mac_nxt));
  ldr_shift #(.NB(STRAP_BYTES)) u_strap_sh (
    .clk(clk), .rst_n(rst_n), .en(take && state == ST_STRAP), .din(byte_dat), .nxt(strap_nxt));
  ldr_shift #(.NB(ADR_BYTES)) u_badr_sh (
    .clk(clk), .rst_n(rst_n), .en(take && state == ST_BADDR), .din(byte_dat), .nxt(badr_nxt));
  ldr_shift #(.NB(WORD_BYTES)) u_word_sh (
    .clk(clk), .rst_n(rst_n), .en(take && state == ST_WORD), .din(byte_dat), .nxt(word_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_SIG;
      ptr         <= ADDR_W'(A_SIG);
      idx         <= '0;
      bursts_left <= '0;
      words_left  <= '0;
      fetching    <= 1'b0;
      busy        <= 1'b1;
      dev_ready   <= 1'b0;
      load_err    <= 1'b0;
      mac_addr    <= MAC_DEFAULT;
      strap_cfg   <= STRAP_DEFAULT;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else if (start) begin
      state     <= ST_SIG;
      ptr       <= ADDR_W'(A_SIG);
      idx       <= '0;
      fetching  <= 1'b0;
      wr_valid  <= 1'b0;
      busy      <= 1'b1;
      dev_ready <= 1'b0;
    end else begin
      if (go) fetching <= 1'b1;
      if (byte_vld) begin
        fetching <= 1'b0;
        ptr      <= ptr + 1'b1;
        if (byte_err) begin
          load_err  <= 1'b1;
          state     <= ST_IDLE;
          busy      <= 1'b0;
          dev_ready <= 1'b1;
        end else begin
          case (state)
            ST_SIG: begin
              if (byte_dat == SIG_OK) begin
                state <= ST_MAC;
                idx   <= '0;
              end else begin
                state <= ST_IDLE; busy <= 1'b0; dev_ready <= 1'b1;
              end
            end
            ST_MAC: begin
              if (idx == IDX_W'(MAC_BYTES - 1)) begin
                mac_addr <= mac_nxt;
                state    <= ST_SSIG;
              end else idx <= idx + 1'b1;
            end
            ST_SSIG: begin
              idx <= '0;
              if (byte_dat == SIG_OK) state <= ST_STRAP;
              else begin
                state <= ST_BSIG;
                ptr   <= ADDR_W'(A_BSIG);
              end
            end
            ST_STRAP: begin
              if (idx == IDX_W'(STRAP_BYTES - 1)) begin
                strap_cfg <= strap_nxt;
                state     <= ST_BSIG;
              end else idx <= idx + 1'b1;
            end
            ST_BSIG: begin
              if (byte_dat == SIG_OK) state <= ST_NBURST;
              else begin
                state <= ST_IDLE; busy <= 1'b0; dev_ready <= 1'b1;
              end
            end
            ST_NBURST: begin
              bursts_left <= byte_dat;
              idx         <= '0;
              if (byte_dat == 8'd0) begin
                state <= ST_IDLE; busy <= 1'b0; dev_ready <= 1'b1;
              end else state <= ST_BADDR;
            end
            ST_BADDR: begin
              if (idx == IDX_W'(ADR_BYTES - 1)) begin
                wr_addr <= badr_nxt;
                state   <= ST_BCNT;
              end else idx <= idx + 1'b1;
            end
            ST_BCNT: begin
              words_left <= byte_dat;
              idx        <= '0;
              if (byte_dat != 8'd0) state <= ST_WORD;
              else if (bursts_left == 8'd1) begin
                state <= ST_IDLE; busy <= 1'b0; dev_ready <= 1'b1;
              end else begin
                bursts_left <= bursts_left - 1'b1;
                state       <= ST_BADDR;
              end
            end
            ST_WORD: begin
              if (idx == IDX_W'(WORD_BYTES - 1)) begin
                wr_data  <= word_nxt;
                wr_valid <= 1'b1;
                state    <= ST_WRITE;
              end else idx <= idx + 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (state == ST_WRITE && wr_valid && wr_ready) begin
        wr_valid   <= 1'b0;
        wr_addr    <= wr_addr + REG_AW'(WORD_BYTES);
        words_left <= words_left - 1'b1;
        idx        <= '0;
        if (words_left != 8'd1) state <= ST_WORD;
        else if (bursts_left == 8'd1) begin
          state <= ST_IDLE; busy <= 1'b0; dev_ready <= 1'b1;
        end else begin
          bursts_left <= bursts_left - 1'b1;
          state       <= ST_BADDR;
        end
      end
    end
  end

  // R1
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy != dev_ready);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !restart |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R7
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req_valid);

  // R10
  restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> busy && !wr_valid && !rd_req_valid);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);

  // R9
  reload_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_cmd && busy && !restart && wr_valid && !wr_ready |=> wr_valid);
endmodule

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;
  localparam logic [47:0] MAC_DEF   = 48'h02_AB_CD_EF_01_23;
  localparam logic [71:0] STRAP_DEF = 72'h99_88_77_66_55_44_33_22_11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pin_rst_trig, soft_rst_trig, reload_cmd;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_err;
  logic [10:0] rd_req_addr;
  logic [7:0]  rd_rsp_data;
  logic wr_valid, wr_ready, busy, dev_ready, load_err;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [47:0] mac_addr;
  logic [71:0] strap_cfg;

  eeprom_cfg_loader #(.MAC_DEFAULT(MAC_DEF), .STRAP_DEFAULT(STRAP_DEF)) u_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .pin_rst_trig(pin_rst_trig), .soft_rst_trig(soft_rst_trig),
    .reload_cmd(reload_cmd), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .dev_ready(dev_ready), .load_err(load_err),
    .mac_addr(mac_addr), .strap_cfg(strap_cfg)
  );

  logic [7:0]  mem [0:255];
  logic [47:0] exp_q [$];
  logic [47:0] exp_item;
  logic [47:0] cur_mac;
  logic [71:0] cur_strap;
  int err_addr = -1;
  int n_reads = 0, n_cmp = 0, n_bad = 0, seq_bad = 0, last_addr = -1;
  int exp_reads = 0, cyc = 0, k = 0;
  bit have_pend = 0;
  int paddr = 0, lat = 0;

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // EEPROM model and write scoreboard monitor
  initial begin
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0; rd_rsp_err = 0; wr_ready = 0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 0; rd_rsp_err = 0;
      if (have_pend) begin
        if (lat == 0) begin
          rd_rsp_valid = 1;
          rd_rsp_data  = mem[paddr[7:0]];
          rd_rsp_err   = (paddr == err_addr);
          have_pend    = 0;
        end else lat--;
      end
      rd_req_ready = !have_pend && (cyc % 3 != 1);
      if (rst_n && rd_req_valid && rd_req_ready) begin
        have_pend = 1;
        paddr = int'(rd_req_addr);
        lat = cyc % 3;
        n_reads++;
        if (paddr != last_addr + 1 && paddr != 0 && paddr != 17) seq_bad++;
        last_addr = paddr;
      end
      wr_ready = (cyc % 4 != 2);
      if (rst_n && wr_valid && wr_ready) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R5 unexpected write actual=%h_%h expected=none", wr_addr, wr_data);
        end else begin
          exp_item = exp_q.pop_front();
          if (exp_item != {wr_addr, wr_data}) begin
            n_bad++;
            $display("FAIL R5,R7 write actual=%h_%h expected=%h", wr_addr, wr_data, exp_item);
          end
        end
      end
      cyc++;
    end
  end

  task automatic build(input bit s0, input bit s1, input bit s2, input logic [47:0] m,
                       input logic [71:0] s, input bit bursts, input bit push, input logic [31:0] seed);
    int p;
    logic [15:0] ba [3];
    int nw [3];
    logic [31:0] w;
    ba[0] = 16'h0100; ba[1] = 16'h0200; ba[2] = 16'h0FFC;
    nw[0] = 2; nw[1] = 0; nw[2] = 1;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[0] = s0 ? 8'hA5 : 8'h5A;
    for (int i = 0; i < 6; i++) mem[1 + i] = m[8*i +: 8];
    mem[7] = s1 ? 8'hA5 : 8'h00;
    for (int i = 0; i < 9; i++) mem[8 + i] = s[8*i +: 8];
    mem[17] = s2 ? 8'hA5 : 8'hA4;
    mem[18] = bursts ? 8'd3 : 8'd0;
    p = 19;
    if (bursts) begin
      for (int b = 0; b < 3; b++) begin
        mem[p] = ba[b][7:0]; mem[p+1] = ba[b][15:8]; mem[p+2] = 8'(nw[b]); p += 3;
        for (int j = 0; j < nw[b]; j++) begin
          w = seed ^ (32'h01020304 * (b * 4 + j + 1));
          for (int t = 0; t < 4; t++) mem[p + t] = w[8*t +: 8];
          p += 4;
          if (push && s0 && s2) exp_q.push_back({ba[b] + 16'(4 * j), w});
        end
      end
    end
    if (!s0) exp_reads = 1;
    else begin
      exp_reads = 7 + 1 + (s1 ? 9 : 0) + 1 + (s2 ? 1 + (bursts ? 21 : 0) : 0);
      cur_mac = m;
      if (s1) cur_strap = s;
    end
  endtask

  task automatic pulse_now(input int which);
    if (which == 0) reload_cmd = 1;
    else if (which == 1) pin_rst_trig = 1;
    else soft_rst_trig = 1;
    @(negedge clk); #1;
    reload_cmd = 0; pin_rst_trig = 0; soft_rst_trig = 0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic end_state(input string tag);
    chk(busy == 1'b0 && dev_ready == 1'b1, {"R1 end flags ", tag}, {busy, dev_ready}, 2'b01);
    chk(n_reads == exp_reads, {"R5,R8 read count ", tag}, n_reads, exp_reads);
    chk(mac_addr == cur_mac, {"R3 mac ", tag}, mac_addr, cur_mac);
    chk(strap_cfg == cur_strap, {"R4 strap ", tag}, strap_cfg, cur_strap);
    chk(exp_q.size() == 0, {"R5,R6 writes outstanding ", tag}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; pin_rst_trig = 0; soft_rst_trig = 0; reload_cmd = 0;
    cur_mac = MAC_DEF; cur_strap = STRAP_DEF;
    build(0, 1, 1, 48'h0, 72'h0, 1, 1, 32'h0);
    repeat (5) @(negedge clk);
    chk(busy && !dev_ready, "R1 reset flags", {busy, dev_ready}, 2'b10);
    chk(mac_addr == MAC_DEF && strap_cfg == STRAP_DEF, "R2 reset defaults", mac_addr, MAC_DEF);
    #1 rst_n = 1;
    wait_done();
    end_state("R2 bad image signature");
    chk(load_err == 0, "R11 no error", load_err, 0);

    // full image started by reload while idle
    build(1, 1, 1, 48'hA1_B2_C3_D4_E5_F6, 72'h0F_1E_2D_3C_4B_5A_69_78_87, 1, 1, 32'hDEAD_BEEF);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(0);
    chk(busy && !dev_ready, "R1,R9 start on idle reload", {busy, dev_ready}, 2'b10);
    wait_done();
    end_state("R5 full image");

    // strap section skipped, zero bursts
    build(1, 0, 1, 48'h11_22_33_44_55_66, 72'hFF_EE_DD_CC_BB_AA_99_88_77, 0, 1, 32'h0);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(2);
    wait_done();
    end_state("R4,R6 strap skipped");

    // burst section signature wrong
    build(1, 1, 0, 48'h77_66_55_44_33_22, 72'h12_34_56_78_9A_BC_DE_F0_01, 1, 1, 32'h1234_5678);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(1);
    wait_done();
    end_state("R12 no bursts");

    // reload while busy is ignored
    build(1, 1, 1, 48'hCA_FE_00_BA_BE_01, 72'h01_02_03_04_05_06_07_08_09, 1, 1, 32'h0BAD_F00D);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(0);
    while (n_reads < 5) begin @(negedge clk); #1; end
    pulse_now(0);
    chk(busy == 1, "R9 still busy after ignored reload", busy, 1);
    wait_done();
    end_state("R9 reload while busy");

    // pin reset while busy restarts the load
    build(1, 1, 1, 48'h5E_5E_5E_01_02_03, 72'hAB_CD_EF_01_23_45_67_89_AB, 1, 1, 32'h5555_AAAA);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(0);
    while (n_reads < 3) begin @(negedge clk); #1; end
    k = n_reads;
    pulse_now(1);
    chk(busy == 1, "R10 busy after abort", busy, 1);
    wait_done();
    exp_reads = exp_reads + k;
    end_state("R10 abort restart");

    // read error in burst area
    err_addr = 20;
    build(1, 1, 1, 48'hE0_E1_E2_E3_E4_E5, 72'h10_20_30_40_50_60_70_80_90, 1, 0, 32'h0);
    exp_reads = 21;
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(2);
    wait_done();
    end_state("R11 read error");
    chk(load_err == 1, "R11 error flag set", load_err, 1);

    err_addr = -1;
    build(1, 1, 1, 48'h01_01_01_02_02_02, 72'h31_32_33_34_35_36_37_38_39, 1, 1, 32'hC0DE_0001);
    n_reads = 0;
    @(negedge clk); #1;
    pulse_now(2);
    wait_done();
    end_state("R11 clean load after error");
    chk(load_err == 1, "R11 error flag sticky", load_err, 1);
    chk(seq_bad == 0, "R8 read address order", seq_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule